// File: doc/BRIEF.md
# Program Memory Map Decoder

This block sits between the instruction fetch unit and the code storage of a small microcontroller. Each fetch address is routed to one of two on-chip flash blocks, to the external code bus, or is marked as inaccessible. The lower block holds 16 KB at the bottom of the space. The upper block holds 8 KB, and its normal home is the top 8 KB. An external-mode pin decides whether the whole space is served from outside the chip. Otherwise a 2-bit map setting chooses where the upper block appears.

In internal mode, no fetch ever reaches the external bus. A fetch that no on-chip block covers raises a one-cycle fault and returns an all-ones fill byte. For every accepted fetch, the decoder registers the block selects, the in-block offset, the external request and the fault flag, and presents them one cycle later. The map setting is loaded through a single-register write port.

Top module: `prog_map_decoder`

## Requirements
- R1: After reset, every output is 0 and the map setting is 00, so in internal mode a fetch from 0000H goes to the upper block.
- R2: With `ext_sel_n` low, every fetch address raises `ext_req` with `offset` equal to the address, whatever the map setting.
- R3: With `ext_sel_n` high, `ext_req` never rises.
- R4: Map setting 00 in internal mode behaves as follows. 0000H–1FFFH goes to the upper block with offset = address. 2000H–3FFFH goes to the lower block with offset = address. E000H–FFFFH goes to the upper block with offset = address − E000H. All other addresses fault.
- R5: Map setting 01 in internal mode behaves as follows. 0000H–3FFFH goes to the lower block with offset = address. E000H–FFFFH goes to the upper block with offset = address − E000H. All other addresses fault.
- R6: Map settings 10 and 11 in internal mode behave as follows. 0000H–3FFFH goes to the lower block with offset = address. Every other address faults, and the upper block is never selected.
- R7: A faulting fetch raises `fault` for exactly one cycle, with `fill_data` = FFH and `offset` = 0. In every other cycle `fill_data` is 00H.
- R8: Results appear in the cycle after the clock edge that samples `fetch_valid` high. A cycle with `fetch_valid` low produces no select, request or fault.
- R9: `cfg_we` high loads `cfg_wdata` at the clock edge, and fetches from the next edge on use the new setting. With `cfg_we` low, `cfg_wdata` has no effect.
- R10: Each fetch produces exactly one of `sel_lo`, `sel_hi`, `ext_req`, `fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_sel_n | input | 1 | Low: whole code space served externally |
| cfg_we | input | 1 | Map setting write strobe |
| cfg_wdata | input | 2 | Map setting write value |
| fetch_valid | input | 1 | Fetch address valid this cycle |
| fetch_addr | input | ADDR_W | Fetch address |
| sel_lo | output | 1 | Lower flash block selected |
| sel_hi | output | 1 | Upper flash block selected |
| ext_req | output | 1 | External code bus request |
| fault | output | 1 | Inaccessible address pulse |
| offset | output | ADDR_W | Offset within the selected target |
| fill_data | output | DATA_W | FFH on a fault, else 00H |

## Verification
Every result of a fetch is due exactly one edge after the edge that samples it. The bench therefore drives a fetch on a falling edge, drops `fetch_valid` on the next falling edge, and compares all outputs at that moment. A fault is checked again one falling edge later to confirm that the pulse ended. A map write takes effect at the edge that loads it, so the bench issues each fetch no sooner than the falling edge after the write strobe.

// File: rtl/prog_map_decoder.sv
module prog_map_decoder #(
  parameter int ADDR_W     = 16,
  parameter int LO_BYTES   = 16384,
  parameter int HI_BYTES   = 8192,
  parameter int DATA_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_sel_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_wdata,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              sel_lo,
  output logic              sel_hi,
  output logic              ext_req,
  output logic              fault,
  output logic [ADDR_W-1:0] offset,
  output logic [DATA_W-1:0] fill_data
);

  localparam logic [ADDR_W:0] LO_LIM  = (ADDR_W+1)'(LO_BYTES);
  localparam logic [ADDR_W:0] HI_LEN  = (ADDR_W+1)'(HI_BYTES);
  localparam logic [ADDR_W:0] HI_BASE = (ADDR_W+1)'((1 << ADDR_W) - HI_BYTES);

  typedef enum logic [1:0] {RT_FAULT, RT_LO, RT_HI, RT_EXT} route_t;

  logic [1:0]        map_q;
  logic [ADDR_W:0]   addr_x;
  route_t            route;
  logic [ADDR_W-1:0] off_d;
  logic              hi_low_win, lo_win, hi_top_win;

  assign addr_x     = {1'b0, fetch_addr};
  assign hi_low_win = (map_q == 2'b00) && (addr_x < HI_LEN);
  assign lo_win     = addr_x < LO_LIM;
  assign hi_top_win = !map_q[1] && (addr_x >= HI_BASE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      map_q <= 2'b00;
    else if (cfg_we) map_q <= cfg_wdata;

  always_comb begin
    route = RT_FAULT;
    off_d = '0;
    if (!ext_sel_n) begin
      route = RT_EXT;
      off_d = fetch_addr;
    end else if (hi_low_win) begin
      route = RT_HI;
      off_d = fetch_addr;
    end else if (lo_win) begin
      route = RT_LO;
      off_d = fetch_addr;
    end else if (hi_top_win) begin
      route = RT_HI;
      off_d = fetch_addr - HI_BASE[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_lo    <= 1'b0;
      sel_hi    <= 1'b0;
      ext_req   <= 1'b0;
      fault     <= 1'b0;
      offset    <= '0;
      fill_data <= '0;
    end else begin
      sel_lo    <= fetch_valid && route == RT_LO;
      sel_hi    <= fetch_valid && route == RT_HI;
      ext_req   <= fetch_valid && route == RT_EXT;
      fault     <= fetch_valid && route == RT_FAULT;
      offset    <= fetch_valid ? off_d : '0;
      fill_data <= (fetch_valid && route == RT_FAULT) ? '1 : '0;
    end

  a_r10_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sel_lo, sel_hi, ext_req, fault}) == ($past(fetch_valid) ? 1 : 0));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !(sel_lo || sel_hi || ext_req || fault));

  a_r3_no_ext_internal: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sel_n |=> !ext_req);

  a_r2_ext_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !ext_sel_n) |=> (ext_req && offset == $past(fetch_addr)));

  a_r6_hi_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    map_q[1] |=> !sel_hi);

  a_r7_fill_ones: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (fill_data == '1 && offset == '0));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !$past(fetch_valid, 2)) |=> !fault || $past(fetch_valid));

  a_r4_lo_range: assert property (@(posedge clk) disable iff (!rst_n)
    sel_lo |-> ({1'b0, offset} < LO_LIM));

endmodule

// File: tb/prog_map_decoder_tb_top.sv
module prog_map_decoder_tb_top;
  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ext_sel_n = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_wdata = 2'b00;
  logic          fetch_valid = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          sel_lo, sel_hi, ext_req, fault;
  logic [AW-1:0] offset;
  logic [DW-1:0] fill_data;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  prog_map_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .ext_sel_n(ext_sel_n), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .sel_lo(sel_lo), .sel_hi(sel_hi), .ext_req(ext_req), .fault(fault),
    .offset(offset), .fill_data(fill_data)
  );

  // packed result: {sel_lo, sel_hi, ext_req, fault, offset, fill}
  function automatic logic [4+AW+DW-1:0] model(input logic [AW-1:0] a,
                                               input logic [1:0] m,
                                               input logic en_n);
    if (!en_n)                        return {4'b0010, a, 8'h00};
    if (m == 2'b00 && a < 16'h2000)   return {4'b0100, a, 8'h00};
    if (a < 16'h4000)                 return {4'b1000, a, 8'h00};
    if (!m[1] && a >= 16'hE000)       return {4'b0100, a - 16'hE000, 8'h00};
    return {4'b0001, 16'h0000, 8'hFF};
  endfunction

  task automatic check(input string req, input logic [4+AW+DW-1:0] exp);
    logic [4+AW+DW-1:0] act;
    act = {sel_lo, sel_hi, ext_req, fault, offset, fill_data};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_map(input logic [1:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = ~v;
  endtask

  task automatic fetch(input string req, input logic [AW-1:0] a, input logic [1:0] m);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a;
    @(negedge clk);
    fetch_valid = 1'b0;
    check(req, model(a, m, ext_sel_n));
  endtask

  task automatic t_reset;
    check("R1 outputs", '0);
    fetch("R1 map 00 at reset", 16'h0000, 2'b00);
    check("R1 upper at 0000", {4'b0100, 16'h0000, 8'h00});
  endtask

  task automatic t_external;
    ext_sel_n = 1'b0;
    fetch("R2 ext low", 16'h1234, 2'b00);
    write_map(2'b11);
    fetch("R2 ext top", 16'hFFFF, 2'b11);
    fetch("R2 ext hole", 16'h8000, 2'b11);
    ext_sel_n = 1'b1;
    fetch("R3 internal hole", 16'h8000, 2'b11);
  endtask

  task automatic t_map00;
    write_map(2'b00);
    fetch("R4 upper low edge", 16'h0000, 2'b00);
    fetch("R4 upper low end", 16'h1FFF, 2'b00);
    fetch("R4 lower start", 16'h2000, 2'b00);
    fetch("R4 lower end", 16'h3FFF, 2'b00);
    fetch("R4 hole", 16'h4000, 2'b00);
    fetch("R4 upper top", 16'hE000, 2'b00);
    fetch("R4 upper last", 16'hFFFF, 2'b00);
  endtask

  task automatic t_map01;
    write_map(2'b01);
    fetch("R5 lower 0000", 16'h0000, 2'b01);
    fetch("R5 lower 1FFF", 16'h1FFF, 2'b01);
    fetch("R5 hole DFFF", 16'hDFFF, 2'b01);
    fetch("R5 upper E001", 16'hE001, 2'b01);
  endtask

  task automatic t_map1x;
    write_map(2'b10);
    fetch("R6 lower 0100", 16'h0100, 2'b10);
    fetch("R6 hidden E000", 16'hE000, 2'b10);
    write_map(2'b11);
    fetch("R6 hidden FFFF", 16'hFFFF, 2'b11);
    fetch("R6 lower 3FFF", 16'h3FFF, 2'b11);
  endtask

  task automatic t_fault_pulse;
    fetch("R7 fault", 16'hC000, 2'b11);
    @(negedge clk);
    check("R7 pulse ended", '0);
  endtask

  task automatic t_idle_and_hold;
    @(negedge clk);
    fetch_addr = 16'h0000;
    @(negedge clk);
    check("R8 idle no result", '0);
    @(negedge clk);
    cfg_wdata = 2'b00;
    @(negedge clk);
    cfg_wdata = 2'b01;
    fetch("R9 write ignored without strobe", 16'hE000, 2'b11);
    write_map(2'b01);
    fetch("R9 new map used", 16'hE000, 2'b01);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_pre: begin
      check("R1 outputs in reset", '0);
    end
    rst_n = 1'b1;
    t_reset();
    t_external();
    t_map00();
    t_map01();
    t_map1x();
    t_fault_pulse();
    t_idle_and_hold();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule